// File: doc/BRIEF.md
# Linearized Track Fitter

This block turns the hits of one matched road into track parameters with a linear fit. Each road carries six signed coordinates: one hit position on each of four silicon layers, then the curvature and the azimuth of the outer track. The fit works in the transverse plane only and uses no stereo data. Each result is a row of constants dotted with the coordinate vector, plus a constant offset. The block produces curvature, azimuth and impact parameter. Three more rows of the same form give constraint residuals, and the sum of their squares is reported as a fit-quality figure.

Constants are kept per detector sector. The geometry is symmetric from sector to sector, so one constant layout serves every sector, and a sector index that comes with each road selects the bank. Software fills the banks one 16-bit word at a time through a register write port. A new road can be accepted on every clock cycle. Results appear after a fixed latency, with a valid flag that travels alongside the data.

Top module: `lfit_track_fitter`

## Requirements
- R1: A road presented with `in_valid` high is answered with `out_valid` high exactly 4 clock edges later. One road is accepted per cycle with no gaps needed, and `out_valid` is low in every cycle that does not answer a road.
- R2: Each parameter output equals the signed sum over the six coordinates of coefficient times coordinate, plus the row offset scaled by 2^FRAC, then divided by 2^FRAC. Rows are: 0 curvature (`out_curv`), 1 azimuth (`out_phi`), 2 impact parameter (`out_d0`), 3 to 5 constraint residuals. Columns are: 0 to 3 layer hits, 4 outer curvature, 5 outer azimuth, 6 row offset in output units. Coordinate c occupies `in_coord[12*c +: 12]`.
- R3: The constants used for a road are those of the bank named by its `in_sector`. Banks are independent, and roads of different sectors may follow each other on consecutive cycles.
- R4: The division by 2^FRAC rounds half toward positive infinity. With FRAC=4 and a unit coefficient: 8 gives 1, -8 gives 0, 24 gives 2, -24 gives -1.
- R5: A parameter or residual result outside the signed 16-bit range is clamped to 32767 or -32768.
- R6: `out_chi2` is the sum of the squares of the three 16-bit residual results, clamped to 65535.
- R7: A write with `cfg_we` high stores `cfg_data` as the coefficient at (`cfg_sector`, `cfg_row`, `cfg_col`). A write to row 6 or 7, to column 7, or to a sector at or above N_SECTORS changes no bank.
- R8: A synchronous reset clears `out_valid` and all outputs to zero and discards roads in flight. It leaves the loaded constants intact.
- R9: While `out_valid` is low, all result outputs keep the values of the last answered road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sector | input | SEC_W | Sector bank of the write |
| cfg_row | input | 3 | Row of the write (0..5 valid) |
| cfg_col | input | 3 | Column of the write (0..6 valid, 6 = offset) |
| cfg_data | input | C_W | Signed coefficient or offset |
| in_valid | input | 1 | Road present on the inputs this cycle |
| in_sector | input | SEC_W | Sector bank for this road |
| in_coord | input | 6*X_W | Six signed coordinates, coordinate c at bits 12*c upward |
| out_valid | output | 1 | Results below belong to a road |
| out_curv | output | OUT_W | Fitted curvature, signed |
| out_phi | output | OUT_W | Fitted azimuth, signed |
| out_d0 | output | OUT_W | Fitted impact parameter, signed |
| out_chi2 | output | OUT_W | Sum of squared residuals, unsigned |

## Verification
The bench builds the fitter with N_SECTORS=4 and FRAC=4; the widths keep their defaults. The small FRAC keeps the half-unit rounding points at coordinate values that are easy to hit. It also lets a full-scale coefficient against a full-scale coordinate overflow 16 bits, so both saturation directions can be reached. Four sectors are enough to interleave different banks cycle by cycle. Residual rows get tiny coefficients, so the quality term is exercised both below and at its clamp.

// File: rtl/lfit_pkg.sv
package lfit_pkg;

  // Coordinates per road: four layer hits, outer curvature, outer azimuth.
  localparam int N_INPUTS = 6;
  // Constant columns: one per coordinate plus the row offset.
  localparam int N_COLS = N_INPUTS + 1;
  localparam int OFFSET_COL = N_INPUTS;
  // Three parameter rows and three constraint rows.
  localparam int N_ROWS = 6;
  localparam int N_RESID = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ROW_CURV = 3'd0,
    ROW_PHI  = 3'd1,
    ROW_D0   = 3'd2,
    ROW_RES0 = 3'd3,
    ROW_RES1 = 3'd4,
    ROW_RES2 = 3'd5
  } lfit_row_e;

endpackage

// File: rtl/lfit_coef_bank.sv
// One coefficient column of one row, across all sectors.
// Simple dual port with a registered read, so block RAM can be inferred.
module lfit_coef_bank #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lfit_row_dot.sv
// One fit row: registered products, then sum, round and clamp into a
// registered result. The data path has two register stages.
module lfit_row_dot #(
  parameter int N_IN  = 6,
  parameter int X_W   = 12,
  parameter int C_W   = 16,
  parameter int ACC_W = 36,
  parameter int FRAC  = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic [N_IN*X_W-1:0]     coords,
  input  logic [N_IN*C_W-1:0]     coefs,
  input  logic [C_W-1:0]          offset,
  output logic signed [OUT_W-1:0] result
);

  localparam int P_W = X_W + C_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [P_W-1:0]   prod_q [N_IN];
  logic signed [ACC_W-1:0] off_q;

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_mul
      always_ff @(posedge clk) begin
        prod_q[gi] <= P_W'($signed(coords[gi*X_W +: X_W])) *
                      P_W'($signed(coefs[gi*C_W +: C_W]));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    off_q <= ACC_W'($signed(offset)) <<< FRAC;
  end

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    acc = off_q;
    for (int i = 0; i < N_IN; i++) begin
      acc = acc + ACC_W'(prod_q[i]);
    end
    scaled = (acc + HALF) >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (scaled > MAXV) begin
      result <= MAXV[OUT_W-1:0];
    end else if (scaled < MINV) begin
      result <= MINV[OUT_W-1:0];
    end else begin
      result <= scaled[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/lfit_chi2.sv
// Sum of squared residuals with an unsigned clamp, loaded into a register
// only for answered roads.
module lfit_chi2 #(
  parameter int N_RES = 3,
  parameter int R_W   = 16,
  parameter int Q_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [N_RES*R_W-1:0] resid,
  output logic [Q_W-1:0]       chi2
);

  localparam int SQ_W  = 2 * R_W;
  localparam int SUM_W = SQ_W + $clog2(N_RES + 1);
  localparam logic [SUM_W-1:0] QMAX = SUM_W'({Q_W{1'b1}});

  logic signed [SQ_W-1:0] sq [N_RES];

  genvar gi;
  generate
    for (gi = 0; gi < N_RES; gi++) begin : g_sq
      assign sq[gi] = SQ_W'($signed(resid[gi*R_W +: R_W])) *
                      SQ_W'($signed(resid[gi*R_W +: R_W]));
    end
  endgenerate

  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < N_RES; i++) begin
      total = total + SUM_W'(unsigned'(sq[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chi2 <= '0;
    end else if (load) begin
      chi2 <= (total > QMAX) ? {Q_W{1'b1}} : total[Q_W-1:0];
    end
  end

endmodule

// File: rtl/lfit_track_fitter.sv
// Linearized track fitter: per-sector constant banks, six dot-product rows,
// and a sum of squares for the quality term. Latency 4, one road per cycle.
module lfit_track_fitter #(
  parameter int N_SECTORS = 12,
  parameter int X_W       = 12,
  parameter int C_W       = 16,
  parameter int ACC_W     = 36,
  parameter int FRAC      = 8,
  parameter int OUT_W     = 16,
  localparam int SEC_W    = (N_SECTORS > 1) ? $clog2(N_SECTORS) : 1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [SEC_W-1:0]                    cfg_sector,
  input  logic [2:0]                          cfg_row,
  input  logic [2:0]                          cfg_col,
  input  logic [C_W-1:0]                      cfg_data,
  input  logic                                in_valid,
  input  logic [SEC_W-1:0]                    in_sector,
  input  logic [lfit_pkg::N_INPUTS*X_W-1:0]   in_coord,
  output logic                                out_valid,
  output logic signed [OUT_W-1:0]             out_curv,
  output logic signed [OUT_W-1:0]             out_phi,
  output logic signed [OUT_W-1:0]             out_d0,
  output logic [OUT_W-1:0]                    out_chi2
);

  import lfit_pkg::*;

  localparam int VEC_W = N_INPUTS * X_W;

  // Stage 1: bank reads and coordinate register.
  logic             sec_ok;
  logic [C_W-1:0]   coef_rd [N_ROWS][N_COLS];
  logic [VEC_W-1:0] x1_q;
  logic             v1_q, v2_q, v3_q;

  assign sec_ok = (32'(cfg_sector) < N_SECTORS);

  genvar gr, gc;
  generate
    for (gr = 0; gr < N_ROWS; gr++) begin : g_row
      for (gc = 0; gc < N_COLS; gc++) begin : g_col
        logic hit;
        assign hit = cfg_we && sec_ok &&
                     (cfg_row == ADDR_W'(gr)) && (cfg_col == ADDR_W'(gc));
        lfit_coef_bank #(
          .DEPTH (N_SECTORS),
          .AW    (SEC_W),
          .DW    (C_W)
        ) u_bank (
          .clk   (clk),
          .we    (hit),
          .waddr (cfg_sector),
          .wdata (cfg_data),
          .raddr (in_sector),
          .rdata (coef_rd[gr][gc])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    x1_q <= in_coord;
  end

  // Stages 2 and 3: one dot-product row per output or residual.
  logic [N_INPUTS*C_W-1:0] row_coefs [N_ROWS];
  logic signed [OUT_W-1:0] row_res   [N_ROWS];

  generate
    for (gr = 0; gr < N_ROWS; gr++) begin : g_dot
      for (gc = 0; gc < N_INPUTS; gc++) begin : g_pack
        assign row_coefs[gr][gc*C_W +: C_W] = coef_rd[gr][gc];
      end
      lfit_row_dot #(
        .N_IN  (N_INPUTS),
        .X_W   (X_W),
        .C_W   (C_W),
        .ACC_W (ACC_W),
        .FRAC  (FRAC),
        .OUT_W (OUT_W)
      ) u_dot (
        .clk    (clk),
        .coords (x1_q),
        .coefs  (row_coefs[gr]),
        .offset (coef_rd[gr][OFFSET_COL]),
        .result (row_res[gr])
      );
    end
  endgenerate

  // Valid pipeline alongside the data.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      v3_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      v3_q      <= v2_q;
      out_valid <= v3_q;
    end
  end

  // Stage 4: registered outputs, held between roads.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_curv <= '0;
      out_phi  <= '0;
      out_d0   <= '0;
    end else if (v3_q) begin
      out_curv <= row_res[ROW_CURV];
      out_phi  <= row_res[ROW_PHI];
      out_d0   <= row_res[ROW_D0];
    end
  end

  logic [N_RESID*OUT_W-1:0] resid_vec;
  assign resid_vec = {row_res[ROW_RES2], row_res[ROW_RES1], row_res[ROW_RES0]};

  lfit_chi2 #(
    .N_RES (N_RESID),
    .R_W   (OUT_W),
    .Q_W   (OUT_W)
  ) u_chi2 (
    .clk   (clk),
    .rst   (rst),
    .load  (v3_q),
    .resid (resid_vec),
    .chi2  (out_chi2)
  );

endmodule

// File: rtl/lfit_track_fitter_chk.sv
module lfit_track_fitter_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_curv,
  input logic [OUT_W-1:0] out_phi,
  input logic [OUT_W-1:0] out_d0,
  input logic [OUT_W-1:0] out_chi2
);

  // Cycles since the end of reset, saturating.
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0;
    end else if (cyc != 3'd7) begin
      cyc <= cyc + 3'd1;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 3'd5) && $rose(out_valid)) |-> ($past(in_valid, 4) && !$past(in_valid, 5)));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0) |-> (!out_valid && out_curv == '0 && out_phi == '0 &&
                       out_d0 == '0 && out_chi2 == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ((cyc >= 3'd1) && !out_valid) |-> ($stable(out_curv) && $stable(out_phi) &&
                                       $stable(out_d0) && $stable(out_chi2)));

endmodule

bind lfit_track_fitter lfit_track_fitter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_curv  (out_curv),
  .out_phi   (out_phi),
  .out_d0    (out_d0),
  .out_chi2  (out_chi2)
);

// File: tb/lfit_track_fitter_bench.sv
module lfit_track_fitter_bench;

  localparam int NS   = 4;
  localparam int FR   = 4;
  localparam int SW   = 2;
  localparam int NV   = 10;

  // Each row: sector, then coordinates 0..5.
  localparam int STIM [NV][7] = '{
    '{0,    10,   -20,    30,   -40,   50,   -60},
    '{1,   100,    50,   -25,    75, -100,    12},
    '{2,  -300,   200,   150,  -100,   80,    -5},
    '{3,  2047, -2048,  1000, -1000,  500,  -500},
    '{0,     0,     0,     0,     0,    0,     0},
    '{1,    -1,    -1,    -1,    -1,   -1,    -1},
    '{2,     5,     5,     5,     5,    5,     5},
    '{3,    60,   -70,    80,   -90,   33,    44},
    '{0,  1500,  1500,  1500,  1500, 1500,  1500},
    '{1, -2048, -2048, -2048, -2048, -2048, -2048}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_sector = '0;
  logic [2:0] cfg_row = '0;
  logic [2:0] cfg_col = '0;
  logic [15:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_sector = '0;
  logic [71:0] in_coord = '0;
  logic out_valid;
  logic signed [15:0] out_curv, out_phi, out_d0;
  logic [15:0] out_chi2;

  always #5 clk = ~clk;

  lfit_track_fitter #(.N_SECTORS(NS), .FRAC(FR)) u_lfit_track_fitter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sector(cfg_sector),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_sector(in_sector), .in_coord(in_coord),
    .out_valid(out_valid), .out_curv(out_curv), .out_phi(out_phi),
    .out_d0(out_d0), .out_chi2(out_chi2)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int bc [NS][6][7];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  // Reference from the requirements: R2, R4, R5.
  function automatic int model_row(int s, int r, int x[6]);
    longint acc, q;
    acc = longint'(bc[s][r][6]) <<< FR;
    for (int c = 0; c < 6; c++) acc += longint'(bc[s][r][c]) * longint'(x[c]);
    q = (acc + (longint'(1) <<< (FR - 1))) >>> FR;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  // R6: clamped sum of squares.
  function automatic int model_chi2(int s, int x[6]);
    longint t = 0;
    for (int r = 3; r < 6; r++) begin
      longint v = longint'(model_row(s, r, x));
      t += v * v;
    end
    if (t > 65535) t = 65535;
    return int'(t);
  endfunction

  task automatic raw_write(int s, int r, int c, int v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sector = SW'(s);
    cfg_row = 3'(r);
    cfg_col = 3'(c);
    cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(int s, int r, int c, int v);
    raw_write(s, r, c, v);
    bc[s][r][c] = v;
  endtask

  task automatic drive(int s, int x[6]);
    in_valid = 1'b1;
    in_sector = SW'(s);
    for (int c = 0; c < 6; c++) in_coord[c*12 +: 12] = 12'(x[c]);
  endtask

  function automatic void stim_x(int i, output int x[6]);
    for (int c = 0; c < 6; c++) x[c] = STIM[i][c+1];
  endfunction

  task automatic check_all(string req, int s, int x[6]);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "curv", int'(out_curv), model_row(s, 0, x));
    chk(req, "phi", int'(out_phi), model_row(s, 1, x));
    chk(req, "d0", int'(out_d0), model_row(s, 2, x));
    chk(req, "chi2", int'(out_chi2), model_chi2(s, x));
  endtask

  // Single road; leaves the bench at the negedge where results are visible.
  task automatic fit1(int s, int x[6]);
    @(negedge clk);
    drive(s, x);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int x[6];
    int hc, hp, hd, hq;
    // Constant load: parameter rows moderate, residual rows tiny.
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < 6; r++)
        for (int c = 0; c < 7; c++) begin
          if (c == 6) wr(s, r, c, ((s * 7 + r * 3) % 19) - 9);
          else if (r < 3) wr(s, r, c, (((s * 53 + r * 29 + c * 17) % 61) - 30) * 4);
          else wr(s, r, c, ((s + r + c) % 3) - 1);
        end

    // R8: reset state.
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8", "out_valid after reset", int'(out_valid), 0);
    chk("R8", "curv after reset", int'(out_curv), 0);
    chk("R8", "chi2 after reset", int'(out_chi2), 0);

    // R1 R2 R3: back-to-back stream over the table, sectors interleaved.
    for (int t = 0; t < NV + 5; t++) begin
      @(negedge clk);
      if (t >= 4 && t - 4 < NV) begin
        stim_x(t - 4, x);
        check_all("R2", STIM[t - 4][0], x);
      end else begin
        chk("R1", "out_valid idle", int'(out_valid), 0);
      end
      if (t < NV) begin
        stim_x(t, x);
        drive(STIM[t][0], x);
      end else begin
        in_valid = 1'b0;
      end
    end

    // R1: alternating valid, out_valid follows 4 edges later.
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (t >= 4) chk("R1", "alternating out_valid", int'(out_valid), ((t - 4) % 2 == 0 && t - 4 < 6) ? 1 : 0);
      if (t < 6 && t % 2 == 0) begin
        stim_x(t, x);
        drive(STIM[t][0], x);
      end else begin
        in_valid = 1'b0;
      end
    end

    // R3: same coordinates in two sectors use their own banks.
    stim_x(1, x);
    fit1(2, x);
    check_all("R3", 2, x);
    fit1(3, x);
    check_all("R3", 3, x);

    // R4: rounding, sector 0 row 0 reduced to a unit coefficient.
    for (int c = 0; c < 7; c++) wr(0, 0, c, (c == 0) ? 1 : 0);
    x = '{8, 0, 0, 0, 0, 0};    fit1(0, x); chk("R4", "+0.5", int'(out_curv), 1);
    x = '{-8, 0, 0, 0, 0, 0};   fit1(0, x); chk("R4", "-0.5", int'(out_curv), 0);
    x = '{24, 0, 0, 0, 0, 0};   fit1(0, x); chk("R4", "+1.5", int'(out_curv), 2);
    x = '{-24, 0, 0, 0, 0, 0};  fit1(0, x); chk("R4", "-1.5", int'(out_curv), -1);

    // R5: clamp both ways on sector 3 azimuth.
    for (int c = 0; c < 7; c++) wr(3, 1, c, (c == 0) ? 32767 : 0);
    x = '{2047, 0, 0, 0, 0, 0};  fit1(3, x); chk("R5", "positive clamp", int'(out_phi), 32767);
    x = '{-2048, 0, 0, 0, 0, 0}; fit1(3, x); chk("R5", "negative clamp", int'(out_phi), -32768);

    // R6: residuals 1,2,-3 per unit of coordinate 0 in sector 2.
    for (int r = 3; r < 6; r++)
      for (int c = 0; c < 7; c++)
        wr(2, r, c, (c != 0) ? 0 : (r == 3) ? 16 : (r == 4) ? 32 : -48);
    x = '{10, 0, 0, 0, 0, 0};  fit1(2, x); chk("R6", "chi2 10,20,-30", int'(out_chi2), 1400);
    x = '{100, 0, 0, 0, 0, 0}; fit1(2, x); chk("R6", "chi2 clamp", int'(out_chi2), 65535);

    // R9: outputs hold while idle.
    hc = int'(out_curv); hp = int'(out_phi); hd = int'(out_d0); hq = int'(out_chi2);
    repeat (3) @(negedge clk);
    chk("R9", "out_valid idle", int'(out_valid), 0);
    chk("R9", "curv held", int'(out_curv), hc);
    chk("R9", "phi held", int'(out_phi), hp);
    chk("R9", "d0 held", int'(out_d0), hd);
    chk("R9", "chi2 held", int'(out_chi2), hq);

    // R7: writes to row 7, row 6 and column 7 change nothing.
    raw_write(1, 6, 0, 12345);
    raw_write(1, 7, 2, -999);
    raw_write(1, 0, 7, 20000);
    raw_write(1, 2, 7, -20000);
    stim_x(7, x);
    fit1(1, x);
    check_all("R7", 1, x);

    // R8: reset with a road in flight; constants survive.
    @(negedge clk);
    stim_x(2, x);
    drive(0, x);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk("R8", "flushed road", int'(out_valid), 0);
    end
    chk("R8", "curv cleared", int'(out_curv), 0);
    stim_x(2, x);
    fit1(2, x);
    check_all("R8", 2, x);

    finish_run();
  end

endmodule